// File: doc/BRIEF.md
# Reset-Qualified Configuration and Serial EEPROM Loader

This block watches the system reset line and sorts each pulse by length. A pulse shorter than a short threshold is ignored. A pulse that reaches the short threshold puts the block's outputs into an inactive state for as long as the line stays high. A pulse that reaches the long threshold counts as a power-on reset. When the line is released after a power-on reset, the block samples its strap inputs into three configuration bytes, a bus-width flag, a config-source flag and three signature bits. It then reads a small Microwire-style serial EEPROM.

The EEPROM holds 16 words of 16 bits. Words 0 to 7 always fill an identity table that the host reads through a 32-byte window. When the config-source strap is high, word 14 and the low byte of word 15 replace the strapped configuration. The high byte of word 15 is an unlock code. While that code is anything other than 73h and a load-enable bit of configuration byte B is set, host writes to the data port drive the EEPROM pins directly. This lets a blank part be programmed in place. Host control of the pins lasts until the next power-on reset.

Top module: `cfg_boot_loader`

## Requirements
- R1: A reset pulse shorter than SHORT_CYC clock cycles has no effect. `io_inactive` stays 0, no load starts, and all configuration outputs keep their values.
- R2: Once `bus_rst` has been sampled high for SHORT_CYC consecutive edges, `io_inactive` is 1. It returns to 0 at the first edge that samples `bus_rst` low. A pulse shorter than LONG_CYC edges never starts a load.
- R3: After a pulse of at least LONG_CYC edges, `busy` rises within a few cycles of the release. At the edge where `busy` rises, `cfg_a`, `cfg_b`, `cfg_c`, `bus_wide`, `cfg_from_ee` and `sig_hi` take the strap values. Before the first power-on reset, all of them read 0.
- R4: When `strap_eecfg` was 1, the load overwrites `cfg_a` with the low byte of word 14, `cfg_b` with its high byte, and `cfg_c` with the low byte of word 15. When `strap_eecfg` was 0, the strapped values remain.
- R5: Words 0 to 7 always load the identity table. Window address `a` returns byte `a[1]` of word `a[4:2]`, where byte 0 is the low byte. Each odd address therefore mirrors the even address below it. Read data appears one clock after the address.
- R6: `busy` stays 1 until the last word is stored. Host writes made while `busy` is 1 are ignored.
- R7: After a load, `prog_en` is 1 exactly when the high byte of word 15 differs from 73h.
- R8: When `busy` is 0, `io_inactive` is 0, `prog_en` is 1 and bit 7 of `cfg_b` is 1, each host write drives `host_wdata[3]`, `[2]` and `[1]` onto `ee_cs`, `ee_sk` and `ee_di` from the next cycle.
- R9: When `prog_en` is 0 or bit 7 of `cfg_b` is 0, host writes leave the EEPROM pins at 0.
- R10: After a host pin write, the pins hold their host values through later resets shorter than LONG_CYC. Only a power-on reset returns the pins to the loader and reloads.
- R11: Each read frame raises `ee_cs` and then sends the bits 1, 1, 0 and the 4-bit word address, most significant bit first, on `ee_di`. It then takes 16 data bits, most significant bit first, from `ee_do`, one per `ee_sk` pulse. The EEPROM model updates `ee_do` on the rising `ee_sk` edges that follow the address. The block reads 9 frames, or 10 when `strap_eecfg` is 1. Word 14 is read first when it is read at all.
- R12: `ee_sk` is 0 whenever `ee_cs` is 0 during a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high device reset |
| bus_rst | input | 1 | System reset line under qualification |
| strap_a | input | 8 | Strap value for configuration byte A |
| strap_b | input | 8 | Strap value for configuration byte B |
| strap_c | input | 8 | Strap value for configuration byte C |
| strap_wide | input | 1 | Strap: 1 selects 16-bit bus width |
| strap_eecfg | input | 1 | Strap: 1 takes configuration from EEPROM |
| strap_sig | input | 3 | Strap for the top three signature bits |
| ee_do | input | 1 | Serial data from the EEPROM |
| host_wr | input | 1 | Host write strobe for the data port |
| host_wdata | input | 16 | Host write data |
| id_rd_addr | input | 5 | Identity window byte address |
| io_inactive | output | 1 | Outputs-inactive state during a qualified reset |
| busy | output | 1 | EEPROM load in progress; host locked out |
| cfg_a | output | 8 | Configuration byte A |
| cfg_b | output | 8 | Configuration byte B (bit 7: load-enable) |
| cfg_c | output | 8 | Configuration byte C |
| bus_wide | output | 1 | Latched bus-width flag |
| cfg_from_ee | output | 1 | Latched config-source flag |
| sig_hi | output | 3 | Latched top signature bits |
| prog_en | output | 1 | In-place programming permitted |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| id_rd_data | output | 8 | Identity window read data |

## Verification
The bench builds the block with SHORT_CYC=4, LONG_CYC=40 and SK_DIV=2. With these values, pulses just below and just above both thresholds take only a few dozen cycles. A full ten-word load takes about a thousand cycles, so eight randomized power-on rounds and a directed programming session fit in one short run. The small divider also keeps the EEPROM model's timing margin at its tightest: the data bit is sampled two cycles after the model updates it.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  localparam logic [7:0] UNLOCK_CODE = 8'h73;
  localparam int         PROG_BIT    = 7;
  localparam int         ID_WORDS    = 8;
  localparam logic [3:0] CFG_WORD    = 4'hE;
  localparam logic [3:0] CODE_WORD   = 4'hF;
  localparam int         FRAME_BITS  = 23;

  typedef enum logic [1:0] {LD_IDLE, LD_ISSUE, LD_WAIT} ld_state_t;
  typedef enum logic [1:0] {SR_IDLE, SR_RUN, SR_GAP} sr_state_t;
endpackage

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int SHORT_CYC = 13,
  parameter int LONG_CYC  = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_rst,
  output logic io_inactive,
  output logic por_release
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          regload;

  assign cnt_nxt = (cnt == LONG_V) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      regload     <= 1'b0;
      io_inactive <= 1'b0;
      por_release <= 1'b0;
    end else begin
      por_release <= 1'b0;
      if (bus_rst) begin
        cnt         <= cnt_nxt;
        io_inactive <= (cnt_nxt >= SHORT_V);
        if (cnt_nxt == LONG_V) regload <= 1'b1;
      end else begin
        cnt         <= '0;
        io_inactive <= 1'b0;
        if (regload) begin
          por_release <= 1'b1;
          regload     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import cfg_boot_pkg::*;
#(
  parameter int SK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [3:0]  addr,
  input  logic        ser_do,
  output logic        cs,
  output logic        sk,
  output logic        di,
  output logic        done,
  output logic [15:0] word
);
  localparam int DW = (SK_DIV > 1) ? $clog2(SK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SK_DIV - 1);
  localparam logic [4:0]    LAST_BIT = 5'(FRAME_BITS - 1);

  sr_state_t     st;
  logic [DW-1:0] div;
  logic          tick, ph;
  logic [4:0]    idx;
  logic [6:0]    hdr_sh;

  assign tick = (div == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SR_IDLE; div <= '0; ph <= 1'b0; idx <= '0; hdr_sh <= '0;
      cs <= 1'b0; sk <= 1'b0; di <= 1'b0; done <= 1'b0; word <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SR_IDLE: begin
          div <= '0;
          if (start) begin
            st     <= SR_RUN;
            cs     <= 1'b1;
            sk     <= 1'b0;
            di     <= 1'b1;
            hdr_sh <= {2'b10, addr, 1'b0};
            idx    <= '0;
            ph     <= 1'b0;
          end
        end
        SR_RUN: begin
          if (tick) begin
            div <= '0;
            if (!ph) begin
              sk <= 1'b1;
              ph <= 1'b1;
            end else begin
              sk <= 1'b0;
              ph <= 1'b0;
              if (idx >= 5'd7) word <= {word[14:0], ser_do};
              if (idx == LAST_BIT) begin
                st <= SR_GAP;
                cs <= 1'b0;
                di <= 1'b0;
              end else begin
                idx    <= idx + 1'b1;
                di     <= hdr_sh[6];
                hdr_sh <= {hdr_sh[5:0], 1'b0};
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            div  <= '0;
            done <= 1'b1;
            st   <= SR_IDLE;
          end else begin
            div <= div + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/id_store.sv
module id_store #(
  parameter int WORDS = 8,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  input  logic          rsel_hi,
  output logic [7:0]    rdata
);
  logic [7:0] bank_q [2];
  logic       sel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata[8*b +: 8];
      bank_q[b] <= mem[raddr];
    end
  end

  always_ff @(posedge clk) sel_q <= rsel_hi;

  assign rdata = sel_q ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_boot_pkg::*;
#(
  parameter int SHORT_CYC = 13,
  parameter int LONG_CYC  = 1_000_000,
  parameter int SK_DIV    = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_rst,
  input  logic [7:0]  strap_a,
  input  logic [7:0]  strap_b,
  input  logic [7:0]  strap_c,
  input  logic        strap_wide,
  input  logic        strap_eecfg,
  input  logic [2:0]  strap_sig,
  input  logic        ee_do,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  input  logic [4:0]  id_rd_addr,
  output logic        io_inactive,
  output logic        busy,
  output logic [7:0]  cfg_a,
  output logic [7:0]  cfg_b,
  output logic [7:0]  cfg_c,
  output logic        bus_wide,
  output logic        cfg_from_ee,
  output logic [2:0]  sig_hi,
  output logic        prog_en,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  output logic [7:0]  id_rd_data
);
  localparam int IAW = $clog2(ID_WORDS);
  localparam logic [3:0] LAST_ID = 4'(ID_WORDS - 1);

  logic        por_release;
  ld_state_t   ld_st;
  logic [3:0]  wa;
  logic        rd_start, rd_done, rd_cs, rd_sk, rd_di;
  logic [15:0] rd_word;
  logic        id_we;
  logic        sess, bb_cs, bb_sk, bb_di, bb_ok;
  logic        unused_wdata;

  assign unused_wdata = ^{host_wdata[15:4], host_wdata[0]};

  rst_qualifier #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_rstq (
    .clk(clk), .rst(rst), .bus_rst(bus_rst),
    .io_inactive(io_inactive), .por_release(por_release)
  );

  assign rd_start = (ld_st == LD_ISSUE);

  ee_word_reader #(.SK_DIV(SK_DIV)) u_rd (
    .clk(clk), .rst(rst), .start(rd_start), .addr(wa), .ser_do(ee_do),
    .cs(rd_cs), .sk(rd_sk), .di(rd_di), .done(rd_done), .word(rd_word)
  );

  assign id_we = (ld_st == LD_WAIT) && rd_done && !wa[3];

  id_store #(.WORDS(ID_WORDS)) u_id (
    .clk(clk), .we(id_we), .waddr(wa[IAW-1:0]), .wdata(rd_word),
    .raddr(id_rd_addr[IAW+1:2]), .rsel_hi(id_rd_addr[1]), .rdata(id_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_st <= LD_IDLE; wa <= '0; busy <= 1'b0;
      cfg_a <= '0; cfg_b <= '0; cfg_c <= '0;
      bus_wide <= 1'b0; cfg_from_ee <= 1'b0; sig_hi <= '0; prog_en <= 1'b0;
    end else if (por_release) begin
      cfg_a       <= strap_a;
      cfg_b       <= strap_b;
      cfg_c       <= strap_c;
      bus_wide    <= strap_wide;
      cfg_from_ee <= strap_eecfg;
      sig_hi      <= strap_sig;
      busy        <= 1'b1;
      wa          <= strap_eecfg ? CFG_WORD : CODE_WORD;
      ld_st       <= LD_ISSUE;
    end else begin
      case (ld_st)
        LD_ISSUE: ld_st <= LD_WAIT;
        LD_WAIT: if (rd_done) begin
          if (wa == CFG_WORD) begin
            cfg_a <= rd_word[7:0];
            cfg_b <= rd_word[15:8];
          end
          if (wa == CODE_WORD) begin
            prog_en <= (rd_word[15:8] != UNLOCK_CODE);
            if (cfg_from_ee) cfg_c <= rd_word[7:0];
          end
          if (wa == CODE_WORD) begin
            wa    <= '0;
            ld_st <= LD_ISSUE;
          end else if (wa == LAST_ID) begin
            ld_st <= LD_IDLE;
            busy  <= 1'b0;
          end else begin
            wa    <= wa + 1'b1;
            ld_st <= LD_ISSUE;
          end
        end
        default: ld_st <= LD_IDLE;
      endcase
    end
  end

  assign bb_ok = host_wr && !busy && !io_inactive && prog_en && cfg_b[PROG_BIT];

  always_ff @(posedge clk) begin
    if (rst || por_release) begin
      sess <= 1'b0; bb_cs <= 1'b0; bb_sk <= 1'b0; bb_di <= 1'b0;
    end else if (bb_ok) begin
      sess  <= 1'b1;
      bb_cs <= host_wdata[3];
      bb_sk <= host_wdata[2];
      bb_di <= host_wdata[1];
    end
  end

  assign ee_cs = sess ? bb_cs : rd_cs;
  assign ee_sk = sess ? bb_sk : rd_sk;
  assign ee_di = sess ? bb_di : rd_di;
endmodule

// File: rtl/cfg_boot_loader_sva.sv
module cfg_boot_loader_sva
  import cfg_boot_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_rst,
  input logic [7:0]  strap_a,
  input logic        strap_wide,
  input logic        host_wr,
  input logic [15:0] host_wdata,
  input logic        io_inactive,
  input logic        busy,
  input logic [7:0]  cfg_a,
  input logic [7:0]  cfg_b,
  input logic        bus_wide,
  input logic        prog_en,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di
);
  a_r2_inactive_needs_reset: assert property (@(posedge clk) disable iff (rst)
    io_inactive |-> $past(bus_rst));

  a_r3_straps_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cfg_a == $past(strap_a)) && (bus_wide == $past(strap_wide)) && !$past(bus_rst));

  a_r8_pin_drive: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !busy && !io_inactive && prog_en && cfg_b[PROG_BIT]) |=>
      (ee_cs == $past(host_wdata[3])) && (ee_sk == $past(host_wdata[2])) && (ee_di == $past(host_wdata[1])));

  a_r9_locked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !prog_en) |-> (!ee_cs && !ee_sk));

  a_r12_clock_in_frame: assert property (@(posedge clk) disable iff (rst)
    (busy && !ee_cs) |-> !ee_sk);
endmodule

bind cfg_boot_loader cfg_boot_loader_sva u_sva (
  .clk(clk), .rst(rst), .bus_rst(bus_rst), .strap_a(strap_a), .strap_wide(strap_wide),
  .host_wr(host_wr), .host_wdata(host_wdata), .io_inactive(io_inactive), .busy(busy),
  .cfg_a(cfg_a), .cfg_b(cfg_b), .bus_wide(bus_wide), .prog_en(prog_en),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/tb_cfg_boot_loader.sv
module tb_cfg_boot_loader;
  localparam int SHORT = 4;
  localparam int LONG  = 40;
  localparam int DIV   = 2;

  logic clk = 0, rst = 1, bus_rst = 0;
  logic [7:0] strap_a = 0, strap_b = 0, strap_c = 0;
  logic strap_wide = 0, strap_eecfg = 0;
  logic [2:0] strap_sig = 0;
  logic ee_do = 0, host_wr = 0;
  logic [15:0] host_wdata = 0;
  logic [4:0] id_rd_addr = 0;
  logic io_inactive, busy, bus_wide, cfg_from_ee, prog_en, ee_cs, ee_sk, ee_di;
  logic [7:0] cfg_a, cfg_b, cfg_c, id_rd_data;
  logic [2:0] sig_hi;

  int total = 0, bad = 0;
  logic io_seen = 0, busy_seen = 0;
  int frames = 0, hdr_err = 0, bitcnt = 0;
  logic [6:0] hdr_in = 0;
  logic [3:0] a_in = 0, first_addr = 0;
  logic [15:0] eemem [16];

  always #2 clk = ~clk;

  cfg_boot_loader #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .SK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .strap_a(strap_a), .strap_b(strap_b),
    .strap_c(strap_c), .strap_wide(strap_wide), .strap_eecfg(strap_eecfg),
    .strap_sig(strap_sig), .ee_do(ee_do), .host_wr(host_wr), .host_wdata(host_wdata),
    .id_rd_addr(id_rd_addr), .io_inactive(io_inactive), .busy(busy), .cfg_a(cfg_a),
    .cfg_b(cfg_b), .cfg_c(cfg_c), .bus_wide(bus_wide), .cfg_from_ee(cfg_from_ee),
    .sig_hi(sig_hi), .prog_en(prog_en), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .id_rd_data(id_rd_data)
  );

  // EEPROM model
  always @(posedge ee_cs) begin
    bitcnt = 0;
    if (busy) frames++;
  end
  always @(posedge ee_sk) begin
    if (bitcnt < 7) begin
      hdr_in = {hdr_in[5:0], ee_di};
      if (bitcnt == 6) begin
        a_in = hdr_in[3:0];
        if (busy && frames == 1) first_addr = a_in;
        if (busy && hdr_in[6:4] != 3'b110) hdr_err++;
      end
    end else if (bitcnt < 23) begin
      ee_do = eemem[a_in][22 - bitcnt];
    end
    bitcnt++;
  end

  always @(negedge clk) begin
    if (io_inactive) io_seen = 1;
    if (busy) busy_seen = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk) bus_rst = 1;
    repeat (n) @(negedge clk);
    bus_rst = 0;
  endtask

  task automatic hwrite(input logic [15:0] v);
    @(negedge clk) begin host_wr = 1; host_wdata = v; end
    @(negedge clk) host_wr = 0;
  endtask

  task automatic do_por(input logic eecfg, input logic [7:0] code, input logic eeload,
                        input logic write_in_busy);
    int n;
    strap_a = 8'($urandom); strap_b = {eeload, 7'($urandom)}; strap_c = 8'($urandom);
    strap_wide = 1'($urandom); strap_sig = 3'($urandom); strap_eecfg = eecfg;
    for (int i = 0; i < 16; i++) eemem[i] = 16'($urandom);
    eemem[14][15] = eeload;
    eemem[15][15:8] = code;
    frames = 0; hdr_err = 0; busy_seen = 0;
    pulse(LONG + 2);
    n = 0;
    while (!busy && n < 10) begin @(negedge clk); n++; end
    chk("R3 busy rises after release", busy, 1);
    chk("R3 cfg_a strap at start", cfg_a, strap_a);
    if (write_in_busy) hwrite(16'h000E);
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk("R6 busy falls after load", busy, 0);
  endtask

  task automatic check_load(input logic eecfg);
    logic [7:0] ea, eb, ec;
    ea = eecfg ? eemem[14][7:0]  : strap_a;
    eb = eecfg ? eemem[14][15:8] : strap_b;
    ec = eecfg ? eemem[15][7:0]  : strap_c;
    chk(eecfg ? "R4 cfg_a" : "R3 cfg_a", cfg_a, ea);
    chk(eecfg ? "R4 cfg_b" : "R3 cfg_b", cfg_b, eb);
    chk(eecfg ? "R4 cfg_c" : "R3 cfg_c", cfg_c, ec);
    chk("R3 flags", {bus_wide, cfg_from_ee, sig_hi}, {strap_wide, eecfg, strap_sig});
    chk("R7 prog_en", prog_en, eemem[15][15:8] != 8'h73);
    chk("R11 frame count", frames, eecfg ? 10 : 9);
    chk("R11 header bits", hdr_err, 0);
    chk("R11 first word", first_addr, eecfg ? 4'hE : 4'hF);
    for (int a = 0; a < 32; a++) begin
      logic [15:0] w;
      @(negedge clk) id_rd_addr = 5'(a);
      @(negedge clk);
      w = eemem[a >> 2];
      chk("R5 identity byte", id_rd_data, a[1] ? w[15:8] : w[7:0]);
    end
  endtask

  initial begin
    void'($urandom(32'h1d5eed));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R3 reset busy", busy, 0);
    chk("R3 reset cfg", {cfg_a, cfg_b, cfg_c}, 0);
    chk("R2 reset io_inactive", io_inactive, 0);
    chk("R9 reset pins", {ee_cs, ee_sk, ee_di}, 0);

    io_seen = 0; busy_seen = 0;
    pulse(SHORT - 1);
    repeat (6) @(negedge clk);
    chk("R1 short pulse no inactive", io_seen, 0);
    chk("R1 short pulse no load", busy_seen, 0);

    io_seen = 0;
    @(negedge clk) bus_rst = 1;
    repeat (SHORT - 1) @(negedge clk);
    chk("R2 before threshold", io_inactive, 0);
    @(negedge clk);
    chk("R2 at threshold", io_inactive, 1);
    bus_rst = 0;
    @(negedge clk);
    chk("R2 drops on release", io_inactive, 0);
    busy_seen = 0;
    pulse(LONG - 1);
    repeat (6) @(negedge clk);
    chk("R2 medium pulse no load", busy_seen, 0);
    chk("R1 cfg untouched", cfg_a, 0);

    for (int r = 0; r < 8; r++) begin
      logic ecf, eel;
      logic [7:0] code;
      ecf  = 1'(r % 2);
      eel  = 1'($urandom);
      code = (r % 3 == 0) ? 8'h73 : 8'($urandom_range(0, 255));
      if (code == 8'h73 && r % 3 != 0) code = 8'h00;
      do_por(ecf, code, eel, 1'b0);
      check_load(ecf);
      hwrite(16'h000E);
      if (prog_en && cfg_b[7])
        chk("R8 pins driven", {ee_cs, ee_sk, ee_di}, 3'b111);
      else
        chk("R9 write ignored", {ee_cs, ee_sk, ee_di}, 3'b000);
    end

    // directed programming session
    do_por(1'b0, 8'h12, 1'b1, 1'b1);
    chk("R6 write in busy ignored", {ee_cs, ee_sk, ee_di}, 3'b000);
    chk("R7 unlocked", prog_en, 1);
    hwrite(16'hFFFA);
    chk("R8 cs1 sk0 di1", {ee_cs, ee_sk, ee_di}, 3'b101);
    hwrite(16'h0004);
    chk("R8 cs0 sk1 di0", {ee_cs, ee_sk, ee_di}, 3'b010);
    pulse(SHORT + 2);
    repeat (4) @(negedge clk);
    chk("R10 pins hold over medium reset", {ee_cs, ee_sk, ee_di}, 3'b010);
    chk("R10 no reload on medium reset", busy, 0);
    do_por(1'b0, 8'h73, 1'b1, 1'b0);
    chk("R10 loader regains pins", {ee_cs, ee_sk, ee_di}, 3'b000);
    chk("R10 reload frames", frames, 9);
    chk("R7 locked", prog_en, 0);
    hwrite(16'h000E);
    chk("R9 locked write ignored", {ee_cs, ee_sk, ee_di}, 3'b000);

    do_por(1'b1, 8'h00, 1'b0, 1'b0);
    check_load(1'b1);
    hwrite(16'h000E);
    chk("R9 load bit clear ignored", {ee_cs, ee_sk, ee_di}, 3'b000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule